// File: doc/BRIEF.md
# Filtered Cache Event Counter

The block counts cache transaction events that pass a programmable qualifier. Each event strobe carries the index of the requesting core or thread, a 3-bit request-type code and a 5-bit data-source code. Three filters can be switched on separately: a per-core bitmap, a request-type match and a data-source match. An event is counted only when every enabled filter accepts it. With all filters off, every event is counted.

Software programs the block through a word-wide register port. Writes take effect at the next clock edge, and reads are combinational. The effective qualifier is a shadow copy of the filter registers. That copy reloads only while counting is disabled, so the qualifier cannot change in the middle of a count. The counter is `CNT_W` bits wide. When it wraps from all-ones to zero, it sets a sticky overflow flag. The interrupt output is high while that flag is set and its enable bit is set.

Register map (word address on `reg_addr_i`): 0 control (bit 0 core filter on, bit 1 request filter on, bit 2 source filter on, bit 3 use the legacy core mask); 1 core bitmap; 2 filter codes (request code in bits [2:0], source code in bits [12:8], legacy 8-bit core mask in bits [23:16]); 3 status (bit 0 overflow, bit 1 reserved-code error, both write-one-to-clear); 4 interrupt enable (bit 0); 5 counter bits [31:0]; 6 counter bits [CNT_W-1:32]. `CNT_W` must lie between 33 and 64, and `NUM_CORES` must not exceed 32.

Top module: `cache_evt_filter_ctr`

## Requirements
- R1: With all filters disabled and `cnt_en_i` high, every event strobe adds exactly one to the counter, whatever its core, request or source code.
- R2: With the core filter enabled (control bit 0), an event counts only if bit `evt_core_i` of the core bitmap (address 1) is set. For example, a bitmap of 0x3 passes only cores 0 and 1.
- R3: With the request filter enabled (control bit 1), an event counts only if its request code equals the programmed code in address 2, bits [2:0]. Valid codes are 4 (read), 5 (write), 6 (atomic store) and 7 (atomic non-store).
- R4: Codes 0 to 3 are reserved. With the request filter enabled and a reserved code programmed, no event counts. Writing a reserved code to address 2, bits [2:0] sets status bit 1, which stays set until a 1 is written to that bit.
- R5: With the source filter enabled (control bit 2), an event counts only if its 5-bit source code equals address 2, bits [12:8]. Example codes: 1 is the local-die cache, 14 is local memory and 16 is cross-socket memory.
- R6: When several filters are enabled, an event counts only if all of them match.
- R7: When control bit 3 is set, the core filter uses the 8-bit legacy mask in address 2, bits [23:16] instead of the bitmap. Cores 8 and above never match the legacy mask.
- R8: While `cnt_en_i` is low, events leave the counter unchanged. `cnt_clr_i` zeroes the counter at the next edge and takes priority over an increment in the same cycle.
- R9: A wrap from all-ones to zero sets status bit 0, which is sticky and cleared by writing 1 to it. `irq_o` is high while status bit 0 and interrupt-enable bit 0 are both set.
- R10: Filter writes made while `cnt_en_i` is high read back at once, but they do not change which events count until `cnt_en_i` has been low for at least one edge.
- R11: After reset, the counter, the status bits, the control bits and `irq_o` are all zero.
- R12: The counter reads at address 5 (low 32 bits) and address 6 (upper bits), and both halves can be written to preload it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event strobe, one event per cycle |
| evt_core_i | input | $clog2(NUM_CORES) | Requesting core/thread index |
| evt_req_i | input | 3 | Request-type code of the event |
| evt_src_i | input | 5 | Data-source code of the event |
| cnt_en_i | input | 1 | Counting enable; the shadow filter reloads while low |
| cnt_clr_i | input | 1 | Synchronous counter clear |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with `NUM_CORES` = 16 and `CNT_W` = 48. Sixteen cores put cores 8 to 15 beyond the 8-bit legacy mask, so the bench can show that the legacy path drops them while the full bitmap still reaches core 15. The 48-bit counter is preloaded to within two counts of all-ones through both counter halves, so the wrap, the sticky flag and the interrupt masking can be checked in a few cycles.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int REQ_W    = 3;
  localparam int SRC_W    = 5;
  localparam int LEGACY_W = 8;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FILT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd6;

  typedef struct packed {
    logic                legacy_sel;
    logic                src_en;
    logic                req_en;
    logic                core_en;
    logic [LEGACY_W-1:0] legacy_mask;
    logic [SRC_W-1:0]    src_code;
    logic [REQ_W-1:0]    req_code;
  } flt_cfg_t;

  // valid request codes have the top bit set
  function automatic logic req_code_valid(input logic [REQ_W-1:0] c);
    return c[REQ_W-1];
  endfunction
endpackage

// File: rtl/evt_cnt_qual.sv
module evt_cnt_qual
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CORES = 16,
  localparam int CORE_IW  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  flt_cfg_t             cfg_i,
  input  logic [NUM_CORES-1:0] core_mask_i,
  input  logic [CORE_IW-1:0]   evt_core_i,
  input  logic [REQ_W-1:0]     evt_req_i,
  input  logic [SRC_W-1:0]     evt_src_i,
  output logic                 match_o
);
  logic [NUM_CORES-1:0] legacy_ext;
  logic [NUM_CORES-1:0] eff_mask;
  logic core_hit, req_hit, src_hit;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_legacy
    if (i < LEGACY_W) begin : g_in
      assign legacy_ext[i] = cfg_i.legacy_mask[i];
    end else begin : g_out
      assign legacy_ext[i] = 1'b0;
    end
  end

  assign eff_mask = cfg_i.legacy_sel ? legacy_ext : core_mask_i;

  always_comb begin
    core_hit = 1'b0;
    if (32'(evt_core_i) < NUM_CORES) core_hit = eff_mask[evt_core_i];
  end

  assign req_hit = req_code_valid(cfg_i.req_code) && (evt_req_i == cfg_i.req_code);
  assign src_hit = (evt_src_i == cfg_i.src_code);

  assign match_o = (!cfg_i.core_en || core_hit) &&
                   (!cfg_i.req_en  || req_hit)  &&
                   (!cfg_i.src_en  || src_hit);

  assert_rsvd_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.req_en && !cfg_i.req_code[REQ_W-1]) |-> !match_o);
  assert_legacy_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.core_en && cfg_i.legacy_sel && (32'(evt_core_i) >= LEGACY_W)) |-> !match_o);
endmodule

// File: rtl/evt_cnt_ctr.sv
module evt_cnt_ctr #(
  parameter int CNT_W = 48,
  localparam int HI_W = CNT_W - 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ld;

  assign ld     = ld_lo_i || ld_hi_i;
  assign wrap_o = inc_i && !clr_i && !ld && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (ld) begin
      if (ld_lo_i) cnt_q[31:0]      <= wdata_i;
      if (ld_hi_i) cnt_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_clr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i && !ld) |=> $stable(cnt_q));
  assert_step_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !ld) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/evt_cnt_regs.sv
module evt_cnt_regs
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int CNT_W     = 48,
  localparam int HI_W     = CNT_W - 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic                 cnt_en_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 wrap_i,
  output logic                 ld_lo_o,
  output logic                 ld_hi_o,
  output flt_cfg_t             sh_cfg_o,
  output logic [NUM_CORES-1:0] sh_mask_o,
  output logic                 irq_o
);
  flt_cfg_t             cfg_q, sh_cfg_q;
  logic [NUM_CORES-1:0] mask_q, sh_mask_q;
  logic                 ovf_q, err_q, irq_en_q;
  logic                 wr_ctrl, wr_mask, wr_filt, wr_stat, wr_irqen;

  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign wr_mask  = we_i && (addr_i == A_CMASK);
  assign wr_filt  = we_i && (addr_i == A_FILT);
  assign wr_stat  = we_i && (addr_i == A_STAT);
  assign wr_irqen = we_i && (addr_i == A_IRQEN);
  assign ld_lo_o  = we_i && (addr_i == A_CNT_LO);
  assign ld_hi_o  = we_i && (addr_i == A_CNT_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      mask_q   <= '0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg_q.core_en    <= wdata_i[0];
        cfg_q.req_en     <= wdata_i[1];
        cfg_q.src_en     <= wdata_i[2];
        cfg_q.legacy_sel <= wdata_i[3];
      end
      if (wr_filt) begin
        cfg_q.req_code    <= wdata_i[2:0];
        cfg_q.src_code    <= wdata_i[12:8];
        cfg_q.legacy_mask <= wdata_i[23:16];
      end
      if (wr_mask)  mask_q   <= wdata_i[NUM_CORES-1:0];
      if (wr_irqen) irq_en_q <= wdata_i[0];
    end
  end

  // shadow tracks programmed values only while counting is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_cfg_q  <= '0;
      sh_mask_q <= '0;
    end else if (!cnt_en_i) begin
      sh_cfg_q  <= cfg_q;
      sh_mask_q <= mask_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ovf_q <= wrap_i || (ovf_q && !(wr_stat && wdata_i[0]));
      err_q <= (wr_filt && !req_code_valid(wdata_i[2:0])) ||
               (err_q && !(wr_stat && wdata_i[1]));
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:   rdata_o[3:0] = {cfg_q.legacy_sel, cfg_q.src_en, cfg_q.req_en, cfg_q.core_en};
      A_CMASK:  rdata_o[NUM_CORES-1:0] = mask_q;
      A_FILT: begin
        rdata_o[2:0]   = cfg_q.req_code;
        rdata_o[12:8]  = cfg_q.src_code;
        rdata_o[23:16] = cfg_q.legacy_mask;
      end
      A_STAT:   rdata_o[1:0] = {err_q, ovf_q};
      A_IRQEN:  rdata_o[0] = irq_en_q;
      A_CNT_LO: rdata_o = cnt_i[31:0];
      A_CNT_HI: rdata_o[HI_W-1:0] = cnt_i[CNT_W-1:32];
      default:  rdata_o = '0;
    endcase
  end

  assign sh_cfg_o  = sh_cfg_q;
  assign sh_mask_o = sh_mask_q;
  assign irq_o     = ovf_q && irq_en_q;

  assert_shadow_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |=> ($stable(sh_cfg_q) && $stable(sh_mask_q)));
  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_q);
  assert_err_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_filt && !wdata_i[2]) |=> err_q);
endmodule

// File: rtl/cache_evt_filter_ctr.sv
module cache_evt_filter_ctr
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int CNT_W     = 48,
  localparam int CORE_IW  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  input  logic [CORE_IW-1:0] evt_core_i,
  input  logic [2:0]         evt_req_i,
  input  logic [4:0]         evt_src_i,
  input  logic               cnt_en_i,
  input  logic               cnt_clr_i,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o
);
  flt_cfg_t             sh_cfg;
  logic [NUM_CORES-1:0] sh_mask;
  logic [CNT_W-1:0]     cnt;
  logic                 wrap, ld_lo, ld_hi, match, inc;

  evt_cnt_regs #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cnt_en_i, .cnt_i(cnt), .wrap_i(wrap),
    .ld_lo_o(ld_lo), .ld_hi_o(ld_hi),
    .sh_cfg_o(sh_cfg), .sh_mask_o(sh_mask), .irq_o
  );

  evt_cnt_qual #(.NUM_CORES(NUM_CORES)) u_qual (
    .clk_i, .rst_ni,
    .cfg_i(sh_cfg), .core_mask_i(sh_mask),
    .evt_core_i, .evt_req_i, .evt_src_i,
    .match_o(match)
  );

  assign inc = evt_valid_i && match && cnt_en_i;

  evt_cnt_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni,
    .inc_i(inc), .clr_i(cnt_clr_i), .ld_lo_i(ld_lo), .ld_hi_i(ld_hi),
    .wdata_i(reg_wdata_i), .cnt_o(cnt), .wrap_o(wrap)
  );

  assert_no_count_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |-> !wrap);
endmodule

// File: tb/sim_cache_evt_filter_ctr.sv
`timescale 1ns/1ps
module sim_cache_evt_filter_ctr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0, cnt_en = 1'b0, cnt_clr = 1'b0, we = 1'b0;
  logic [3:0] evt_core = '0;
  logic [2:0] evt_req = '0, addr = '0;
  logic [4:0] evt_src = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cache_evt_filter_ctr #(.NUM_CORES(16), .CNT_W(48)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_core_i(evt_core),
    .evt_req_i(evt_req), .evt_src_i(evt_src), .cnt_en_i(cnt_en), .cnt_clr_i(cnt_clr),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0]  ctrl;
    logic [15:0] mask;
    logic [31:0] filt;
    logic [3:0]  core;
    logic [2:0]  req;
    logic [4:0]  src;
    logic        hit;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'h0, 16'h0000, 32'h0000_0000, 4'd5,  3'd0, 5'd0,  1'b1}, // R1 no filters
    '{4'h1, 16'h0003, 32'h0000_0000, 4'd1,  3'd4, 5'd1,  1'b1}, // R2 core 1 in 0x3
    '{4'h1, 16'h0003, 32'h0000_0000, 4'd2,  3'd4, 5'd1,  1'b0}, // R2 core 2 outside
    '{4'h1, 16'h8000, 32'h0000_0000, 4'd15, 3'd4, 5'd1,  1'b1}, // R2 top core
    '{4'h2, 16'h0000, 32'h0000_0004, 4'd3,  3'd4, 5'd0,  1'b1}, // R3 read
    '{4'h2, 16'h0000, 32'h0000_0005, 4'd3,  3'd4, 5'd0,  1'b0}, // R3 write filter, read event
    '{4'h2, 16'h0000, 32'h0000_0007, 4'd3,  3'd7, 5'd0,  1'b1}, // R3 atomic non-store
    '{4'h4, 16'h0000, 32'h0000_0E00, 4'd0,  3'd5, 5'd14, 1'b1}, // R5 local memory
    '{4'h4, 16'h0000, 32'h0000_0E00, 4'd0,  3'd5, 5'd15, 1'b0}, // R5 mismatch
    '{4'h7, 16'h0010, 32'h0000_1006, 4'd4,  3'd6, 5'd16, 1'b1}, // R6 all match
    '{4'h7, 16'h0010, 32'h0000_1006, 4'd4,  3'd6, 5'd17, 1'b0}, // R6 source off
    '{4'h7, 16'h0010, 32'h0000_1006, 4'd5,  3'd6, 5'd16, 1'b0}, // R6 core off
    '{4'h9, 16'h0000, 32'h0081_0000, 4'd7,  3'd0, 5'd0,  1'b1}, // R7 legacy bit 7
    '{4'h9, 16'hFFFF, 32'h00FF_0000, 4'd9,  3'd0, 5'd0,  1'b0}, // R7 core 9 beyond legacy
    '{4'h2, 16'h0000, 32'h0000_0002, 4'd0,  3'd2, 5'd0,  1'b0}  // R4 reserved code
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ev(input logic [3:0] c, input logic [2:0] r, input logic [4:0] s);
    @(negedge clk); evt_valid = 1'b1; evt_core = c; evt_req = r; evt_src = s;
    @(negedge clk); evt_valid = 1'b0;
  endtask

  task automatic clr_cnt();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(3'd5, d); chk(d, 0, "R11 counter low");
    rd(3'd3, d); chk(d, 0, "R11 status");
    rd(3'd0, d); chk(d, 0, "R11 control");
    chk(irq, 0, "R11 irq");

    for (int i = 0; i < NV; i++) begin
      cnt_en = 1'b0;
      clr_cnt();
      wr(3'd0, {28'd0, TBL[i].ctrl});
      wr(3'd1, {16'd0, TBL[i].mask});
      wr(3'd2, TBL[i].filt);
      @(negedge clk); cnt_en = 1'b1;
      ev(TBL[i].core, TBL[i].req, TBL[i].src);
      @(negedge clk); cnt_en = 1'b0;
      rd(3'd5, d);
      chk(d, {31'd0, TBL[i].hit}, $sformatf("vector %0d filter result", i));
    end
    cnt_en = 1'b0;

    // R4 reserved write sets sticky error, W1C clears it
    wr(3'd3, 32'h3);
    rd(3'd3, d); chk(d[1], 0, "R4 error cleared");
    wr(3'd2, 32'h0000_0003);
    rd(3'd3, d); chk(d[1], 1, "R4 error set on reserved code");
    wr(3'd3, 32'h2);
    rd(3'd3, d); chk(d[1], 0, "R4 error W1C");

    // R8 disabled counting and clear priority
    wr(3'd0, 32'h0);
    clr_cnt();
    @(negedge clk);
    ev(4'd0, 3'd4, 5'd1);
    rd(3'd5, d); chk(d, 0, "R8 no count while disabled");
    @(negedge clk); cnt_en = 1'b1;
    ev(4'd0, 3'd4, 5'd1);
    ev(4'd1, 3'd5, 5'd2);
    rd(3'd5, d); chk(d, 2, "R1 two events counted");
    @(negedge clk); cnt_clr = 1'b1; evt_valid = 1'b1;
    @(negedge clk); cnt_clr = 1'b0; evt_valid = 1'b0;
    rd(3'd5, d); chk(d, 0, "R8 clear beats increment");

    // R10 filter writes frozen while counting
    @(negedge clk); cnt_en = 1'b0;
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h1);
    clr_cnt();
    @(negedge clk); cnt_en = 1'b1;
    wr(3'd1, 32'h2);
    rd(3'd1, d); chk(d, 32'h2, "R10 readback while counting");
    ev(4'd1, 3'd4, 5'd0);
    rd(3'd5, d); chk(d, 0, "R10 new mask not yet applied");
    ev(4'd0, 3'd4, 5'd0);
    rd(3'd5, d); chk(d, 1, "R10 old mask still applied");
    @(negedge clk); cnt_en = 1'b0;
    @(negedge clk); cnt_en = 1'b1;
    ev(4'd1, 3'd4, 5'd0);
    rd(3'd5, d); chk(d, 2, "R10 new mask applied after disable");

    // R12 preload, R9 wrap and interrupt
    @(negedge clk); cnt_en = 1'b0;
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h3);
    wr(3'd5, 32'hFFFF_FFFE);
    wr(3'd6, 32'h0000_FFFF);
    wr(3'd4, 32'h1);
    rd(3'd6, d); chk(d, 32'hFFFF, "R12 high half preload");
    rd(3'd5, d); chk(d, 32'hFFFF_FFFE, "R12 low half preload");
    @(negedge clk); cnt_en = 1'b1;
    ev(4'd2, 3'd4, 5'd0);
    rd(3'd5, d); rd(3'd6, d2);
    chk({d2, d}, 64'h0000_FFFF_FFFF_FFFF, "R12 count reaches all-ones");
    rd(3'd3, d); chk(d[0], 0, "R9 no overflow before wrap");
    chk(irq, 0, "R9 irq low before wrap");
    ev(4'd2, 3'd4, 5'd0);
    rd(3'd5, d); rd(3'd6, d2);
    chk({d2, d}, 0, "R9 counter wraps to zero");
    rd(3'd3, d); chk(d[0], 1, "R9 overflow flag set");
    chk(irq, 1, "R9 irq raised");
    @(negedge clk); cnt_en = 1'b0;
    wr(3'd4, 32'h0);
    #1; chk(irq, 0, "R9 irq masked");
    rd(3'd3, d); chk(d[0], 1, "R9 flag sticky while masked");
    wr(3'd4, 32'h1);
    #1; chk(irq, 1, "R9 irq unmasked again");
    wr(3'd3, 32'h1);
    rd(3'd3, d); chk(d[0], 0, "R9 flag W1C");
    chk(irq, 0, "R9 irq drops after clear");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule